// File: doc/BRIEF.md
# Bus Connectivity Test Master Sequencer

This block is the initiating side of a board interconnect test. A shared bus of 32 data lines, 16 address lines and 8 control lines runs to a target that holds one test word. The operator first loads a 53-bit test word into the block through a small command port. The word is made of 32 data bits, 16 address bits and 5 looped control bits. The operator then issues a start command. The block raises a test-mode line and drives the word onto the bus with the write line high. It pulses the strobe so that the target stores the word. It then drops write, releases its drivers on all 53 looped lines, and pulses the strobe again. While that second strobe is high the target drives its stored word back.

The block captures the returned word into a result register. It then reports completion and whether the returned word differs from the word that was sent. An open, stuck or shorted line shows up as a mismatch. The loaded word itself is chosen by the operator, usually all zeros, all ones, and the two alternating patterns. Setup, strobe and hold times are set by parameters as numbers of clock cycles, each at least 1.

Top module: `busloop_master`

## Requirements
- R1: After reset, busy, done and mismatch are 0, the result is 0, the data, address and looped control lines are not driven, and all control outputs are 0.
- R2: A command with code 0 loads the data field from wdata[31:0]. Code 1 loads the address field from wdata[15:0] and the looped control field from wdata[20:16]. Code 3 has no effect. Looped control bits 0..4 travel on control lines 0, 3, 4, 5 and 6 in that order.
- R3: A start command (code 2) accepted while idle makes busy high from the next cycle. Control line 7 (test mode) equals busy at all times.
- R4: The write phase lasts SETUP+STROBE+HOLD cycles. Control line 2 (write) is high and all 53 looped lines are driven with the loaded word. Control line 1 (strobe) is high only for the STROBE cycles after the first SETUP cycles.
- R5: In the read phase, write is low and none of the 53 looped lines is driven. This starts SETUP cycles before the read strobe and lasts through its STROBE cycles and the HOLD cycles after it.
- R6: The result register receives the bus value present in the last read-strobe cycle, packed as {looped control[4:0], address[15:0], data[31:0]}.
- R7: Busy lasts exactly 2*(SETUP+STROBE+HOLD) cycles. Done then goes high and stays high until the next accepted start.
- R8: Mismatch is set together with done when the result differs from the loaded word, and is 0 otherwise.
- R9: While busy, start and load commands are ignored. The running sequence and the loaded word are unchanged.
- R10: An accepted start clears done and mismatch from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code: 0 load data, 1 load address/control, 2 start, 3 none |
| cmd_wdata | input | 32 | Command payload |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky completion flag |
| mismatch | output | 1 | Returned word differs from loaded word |
| result | output | 53 | Captured word {control[4:0], address, data} |
| bus_data_o | output | 32 | Data lines, driven value |
| bus_data_oe | output | 1 | Data line driver enable |
| bus_data_i | input | 32 | Data lines, observed value |
| bus_addr_o | output | 16 | Address lines, driven value |
| bus_addr_oe | output | 1 | Address line driver enable |
| bus_addr_i | input | 16 | Address lines, observed value |
| bus_ctl_o | output | 8 | Control lines, driven value |
| bus_ctl_oe | output | 8 | Control line driver enables, per line |
| bus_ctl_i | input | 8 | Control lines, observed value |

## Verification
Two things can happen in the same cycle: a command arriving and the sequence finishing. The bench sends a start in the last busy cycle, the same cycle in which done is set. It then checks that busy stays low afterwards and that done is held. Loads and starts are also sent in the middle of a run. A later run without any new load must then return the original word. A loopback target model in the bench flags any cycle in which both sides drive the bus. It also flips chosen returned bits so that the mismatch path is exercised.

// File: rtl/busloop_pkg.sv
package busloop_pkg;

  localparam int CTL_W      = 8;
  localparam int LOOP_W     = 5;
  localparam int CTL_TEST   = 7;
  localparam int CTL_WRITE  = 2;
  localparam int CTL_STROBE = 1;
  localparam logic [CTL_W-1:0] LOOP_MASK = 8'b0111_1001;

  typedef enum logic [1:0] {
    OP_LOAD_LOW  = 2'd0,
    OP_LOAD_HIGH = 2'd1,
    OP_START     = 2'd2,
    OP_NONE      = 2'd3
  } cmd_op_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSETUP,
    PH_WSTROBE,
    PH_WHOLD,
    PH_TURN,
    PH_RSTROBE,
    PH_RHOLD
  } phase_t;

  function automatic phase_t phase_after(input phase_t p);
    case (p)
      PH_WSETUP:  return PH_WSTROBE;
      PH_WSTROBE: return PH_WHOLD;
      PH_WHOLD:   return PH_TURN;
      PH_TURN:    return PH_RSTROBE;
      PH_RSTROBE: return PH_RHOLD;
      default:    return PH_IDLE;
    endcase
  endfunction

  function automatic logic is_write_phase(input phase_t p);
    return (p == PH_WSETUP) || (p == PH_WSTROBE) || (p == PH_WHOLD);
  endfunction

  function automatic logic is_strobe_phase(input phase_t p);
    return (p == PH_WSTROBE) || (p == PH_RSTROBE);
  endfunction

  // looped field bit k -> control line: 0,3,4,5,6
  function automatic logic [CTL_W-1:0] loop_to_ctl(input logic [LOOP_W-1:0] l);
    logic [CTL_W-1:0] c;
    c = '0;
    c[0] = l[0];
    c[3] = l[1];
    c[4] = l[2];
    c[5] = l[3];
    c[6] = l[4];
    return c;
  endfunction

  function automatic logic [LOOP_W-1:0] ctl_to_loop(input logic [CTL_W-1:0] c);
    return {c[6], c[5], c[4], c[3], c[0]};
  endfunction

endpackage

// File: rtl/busloop_cmd_dec.sv
module busloop_cmd_dec
  import busloop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              busy,
  output logic              start_acc,
  output logic [DATA_W-1:0] pat_data,
  output logic [ADDR_W-1:0] pat_addr,
  output logic [LOOP_W-1:0] pat_loop
);

  localparam int HIGH_W = ADDR_W + LOOP_W;

  cmd_op_t op;
  logic    accept;
  logic    load_low;
  logic    load_high;

  assign op        = cmd_op_t'(cmd_op);
  assign accept    = cmd_valid && !busy;
  assign load_low  = accept && (op == OP_LOAD_LOW);
  assign load_high = accept && (op == OP_LOAD_HIGH);
  assign start_acc = accept && (op == OP_START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_data <= '0;
      pat_addr <= '0;
      pat_loop <= '0;
    end else begin
      if (load_low)
        pat_data <= cmd_wdata;
      if (load_high) begin
        pat_addr <= cmd_wdata[ADDR_W-1:0];
        pat_loop <= cmd_wdata[HIGH_W-1:ADDR_W];
      end
    end
  end

  AST_WORD_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({pat_loop, pat_addr, pat_data}));  // R9

endmodule

// File: rtl/busloop_seq.sv
module busloop_seq
  import busloop_pkg::*;
#(
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC   = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_acc,
  output phase_t phase,
  output logic   busy,
  output logic   cap_en,
  output logic   finish
);

  localparam int MAX_AB  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_LEN = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int TOTAL   = 2 * (SETUP_CYC + STROBE_CYC + HOLD_CYC);
  localparam int RUN_W   = $clog2(TOTAL + 2);

  function automatic logic [CNT_W-1:0] reload(input phase_t p);
    case (p)
      PH_WSETUP, PH_TURN:     return CNT_W'(SETUP_CYC - 1);
      PH_WSTROBE, PH_RSTROBE: return CNT_W'(STROBE_CYC - 1);
      PH_WHOLD, PH_RHOLD:     return CNT_W'(HOLD_CYC - 1);
      default:                return '0;
    endcase
  endfunction

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_end;

  assign phase     = phase_q;
  assign busy      = (phase_q != PH_IDLE);
  assign phase_end = busy && (cnt_q == '0);
  assign cap_en    = phase_end && (phase_q == PH_RSTROBE);
  assign finish    = phase_end && (phase_q == PH_RHOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_acc) begin
      phase_q <= PH_WSETUP;
      cnt_q   <= reload(PH_WSETUP);
    end else if (phase_end) begin
      phase_q <= phase_after(phase_q);
      cnt_q   <= reload(phase_after(phase_q));
    end else if (busy) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  // independent length counter for the run-length property
  logic [RUN_W-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (start_acc)
      run_cnt <= '0;
    else if (busy)
      run_cnt <= run_cnt + 1'b1;
  end

  AST_START_ENTERS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (phase_q == PH_WSETUP));  // R3

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RUN_W'(TOTAL)));  // R7

endmodule

// File: rtl/busloop_pins.sv
module busloop_pins
  import busloop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              busy,
  input  logic              start_acc,
  input  logic              cap_en,
  input  logic              finish,
  input  logic [DATA_W-1:0] pat_data,
  input  logic [ADDR_W-1:0] pat_addr,
  input  logic [LOOP_W-1:0] pat_loop,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CTL_W-1:0]  bus_ctl_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_addr_oe,
  output logic [CTL_W-1:0]  bus_ctl_o,
  output logic [CTL_W-1:0]  bus_ctl_oe,
  output logic [DATA_W+ADDR_W+LOOP_W-1:0] result,
  output logic              done,
  output logic              mismatch
);

  localparam int PAT_W = DATA_W + ADDR_W + LOOP_W;

  logic             drive;
  logic             strobe;
  logic [PAT_W-1:0] sent_word;
  logic [PAT_W-1:0] seen_word;
  logic [PAT_W-1:0] result_q;
  logic             done_q;
  logic             mism_q;

  assign drive     = is_write_phase(phase);
  assign strobe    = is_strobe_phase(phase);
  assign sent_word = {pat_loop, pat_addr, pat_data};
  assign seen_word = {ctl_to_loop(bus_ctl_i), bus_addr_i, bus_data_i};

  assign bus_data_o  = drive ? pat_data : '0;
  assign bus_addr_o  = drive ? pat_addr : '0;
  assign bus_data_oe = drive;
  assign bus_addr_oe = drive;
  assign bus_ctl_oe  = drive ? {CTL_W{1'b1}} : ~LOOP_MASK;

  always_comb begin
    bus_ctl_o             = loop_to_ctl(drive ? pat_loop : '0);
    bus_ctl_o[CTL_TEST]   = busy;
    bus_ctl_o[CTL_WRITE]  = drive;
    bus_ctl_o[CTL_STROBE] = strobe;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
      mism_q   <= 1'b0;
    end else begin
      if (cap_en)
        result_q <= seen_word;
      if (start_acc) begin
        done_q <= 1'b0;
        mism_q <= 1'b0;
      end else if (finish) begin
        done_q <= 1'b1;
        mism_q <= (result_q != sent_word);
      end
    end
  end

  assign result   = result_q;
  assign done     = done_q;
  assign mismatch = mism_q;

  AST_READ_STROBE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ctl_o[CTL_STROBE] && !bus_ctl_o[CTL_WRITE]) |->
      (!bus_data_oe && !bus_addr_oe && ((bus_ctl_oe & LOOP_MASK) == '0)));  // R5

  AST_RELEASE_AHEAD_OF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_ctl_o[CTL_STROBE]) && !bus_ctl_o[CTL_WRITE]) |->
      $past(!bus_data_oe && !bus_addr_oe));  // R5

  AST_WRITE_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ctl_o[CTL_STROBE] && bus_ctl_o[CTL_WRITE]) |->
      (bus_data_oe && bus_addr_oe && (bus_ctl_oe == '1)));  // R4

  AST_STROBE_IN_TEST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ctl_o[CTL_STROBE] |-> bus_ctl_o[CTL_TEST]);  // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_acc) |=> done_q);  // R7

  AST_DONE_CLEARED_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (!done_q && !mism_q));  // R10

  AST_MISMATCH_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mism_q |-> done_q);  // R8

endmodule

// File: rtl/busloop_master.sv
module busloop_master
  import busloop_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int SETUP_CYC  = 4,
  parameter int STROBE_CYC = 4,
  parameter int HOLD_CYC   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  input  logic [1:0]                        cmd_op,
  input  logic [DATA_W-1:0]                 cmd_wdata,
  output logic                              busy,
  output logic                              done,
  output logic                              mismatch,
  output logic [DATA_W+ADDR_W+LOOP_W-1:0]   result,
  output logic [DATA_W-1:0]                 bus_data_o,
  output logic                              bus_data_oe,
  input  logic [DATA_W-1:0]                 bus_data_i,
  output logic [ADDR_W-1:0]                 bus_addr_o,
  output logic                              bus_addr_oe,
  input  logic [ADDR_W-1:0]                 bus_addr_i,
  output logic [CTL_W-1:0]                  bus_ctl_o,
  output logic [CTL_W-1:0]                  bus_ctl_oe,
  input  logic [CTL_W-1:0]                  bus_ctl_i
);

  logic              start_acc;
  logic              cap_en;
  logic              finish;
  phase_t            phase;
  logic [DATA_W-1:0] pat_data;
  logic [ADDR_W-1:0] pat_addr;
  logic [LOOP_W-1:0] pat_loop;

  busloop_cmd_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .busy      (busy),
    .start_acc (start_acc),
    .pat_data  (pat_data),
    .pat_addr  (pat_addr),
    .pat_loop  (pat_loop)
  );

  busloop_seq #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .phase     (phase),
    .busy      (busy),
    .cap_en    (cap_en),
    .finish    (finish)
  );

  busloop_pins #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .busy        (busy),
    .start_acc   (start_acc),
    .cap_en      (cap_en),
    .finish      (finish),
    .pat_data    (pat_data),
    .pat_addr    (pat_addr),
    .pat_loop    (pat_loop),
    .bus_data_i  (bus_data_i),
    .bus_addr_i  (bus_addr_i),
    .bus_ctl_i   (bus_ctl_i),
    .bus_data_o  (bus_data_o),
    .bus_data_oe (bus_data_oe),
    .bus_addr_o  (bus_addr_o),
    .bus_addr_oe (bus_addr_oe),
    .bus_ctl_o   (bus_ctl_o),
    .bus_ctl_oe  (bus_ctl_oe),
    .result      (result),
    .done        (done),
    .mismatch    (mismatch)
  );

endmodule

// File: tb/test_busloop_master.sv
module test_busloop_master;

  localparam int CLK_PERIOD = 10;
  localparam int S  = 4;
  localparam int W  = 4;
  localparam int H  = 4;
  localparam int PW = 53;
  localparam int W_STB_A = S + 1;
  localparam int W_STB_B = S + W;
  localparam int W_END   = S + W + H;
  localparam int R_STB_A = W_END + S + 1;
  localparam int R_STB_B = W_END + S + W;
  localparam int R_END   = 2 * W_END;
  localparam logic [7:0] LOOPS = 8'h79;

  localparam logic [PW-1:0] P_ZERO = '0;
  localparam logic [PW-1:0] P_ONES = '1;
  localparam logic [PW-1:0] P_AAA  = {1'b0, {26{2'b10}}};
  localparam logic [PW-1:0] P_555  = {1'b1, {26{2'b01}}};

  // {pattern, returned-bit flip mask}
  localparam logic [2*PW-1:0] VEC [0:6] = '{
    {P_ZERO, 53'd0},
    {P_ONES, 53'd0},
    {P_AAA,  53'd0},
    {P_555,  53'd0},
    {P_AAA,  53'd1 << 0},
    {P_555,  53'd1 << 40},
    {P_ONES, 53'd1 << 50}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd3;
  logic [31:0] cmd_wdata = '0;
  logic        busy, done, mismatch;
  logic [PW-1:0] result;
  logic [31:0] bus_data_o, bus_data_i;
  logic        bus_data_oe, bus_addr_oe;
  logic [15:0] bus_addr_o, bus_addr_i;
  logic [7:0]  bus_ctl_o, bus_ctl_oe, bus_ctl_i;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busloop_master #(.SETUP_CYC(S), .STROBE_CYC(W), .HOLD_CYC(H)) i_busloop_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .mismatch(mismatch), .result(result),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i),
    .bus_addr_o(bus_addr_o), .bus_addr_oe(bus_addr_oe), .bus_addr_i(bus_addr_i),
    .bus_ctl_o(bus_ctl_o), .bus_ctl_oe(bus_ctl_oe), .bus_ctl_i(bus_ctl_i)
  );

  function automatic logic [7:0] ctl_of(input logic [4:0] l);
    return {1'b0, l[4], l[3], l[2], l[1], 2'b00, l[0]};
  endfunction

  // loopback target model
  logic [PW-1:0] tgt_word = '0;
  logic [PW-1:0] flip = '0;
  logic [PW-1:0] ret;
  logic          tgt_drive;
  logic          clash;

  always @(posedge clk)
    if (bus_ctl_o[7] && bus_ctl_o[2] && bus_ctl_o[1])
      tgt_word <= {bus_ctl_o[6], bus_ctl_o[5], bus_ctl_o[4], bus_ctl_o[3], bus_ctl_o[0],
                   bus_addr_o, bus_data_o};

  always_comb begin
    ret        = tgt_word ^ flip;
    tgt_drive  = bus_ctl_o[7] && !bus_ctl_o[2] && bus_ctl_o[1];
    clash      = tgt_drive && (bus_data_oe || bus_addr_oe || ((bus_ctl_oe & LOOPS) != 0));
    bus_data_i = bus_data_oe ? bus_data_o : (tgt_drive ? ret[31:0] : 32'h0);
    bus_addr_i = bus_addr_oe ? bus_addr_o : (tgt_drive ? ret[47:32] : 16'h0);
    bus_ctl_i  = (bus_ctl_o & bus_ctl_oe) |
                 (~bus_ctl_oe & (tgt_drive ? ctl_of(ret[52:48]) : 8'h00));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic load(input logic [PW-1:0] p);
    send(2'd0, p[31:0]);
    send(2'd1, {11'd0, p[52:48], p[47:32]});
  endtask

  // start, then trace every cycle; optional command injected after cycle inj_n
  task automatic run_test(input logic [PW-1:0] p, input logic [PW-1:0] f, input bit do_load,
                          input int inj_n, input logic [1:0] inj_op, input logic [31:0] inj_d,
                          input string tag);
    int e3 = 0, e4 = 0, e5 = 0, e7 = 0, e8 = 0;
    bit busy_e, wr_e, stb_e, done_e;
    flip = f;
    if (do_load) load(p);
    else @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_wdata = '0;
    for (int n = 1; n <= R_END + 4; n++) begin
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd3;
      busy_e = (n <= R_END);
      wr_e   = (n <= W_END);
      stb_e  = (n >= W_STB_A && n <= W_STB_B) || (n >= R_STB_A && n <= R_STB_B);
      done_e = (n > R_END);
      if (busy !== busy_e || bus_ctl_o[7] !== busy_e) e3++;
      if (wr_e) begin
        if (bus_ctl_o[2] !== 1'b1 || bus_ctl_o[1] !== stb_e || !bus_data_oe || !bus_addr_oe ||
            bus_ctl_oe !== 8'hFF || bus_data_o !== p[31:0] || bus_addr_o !== p[47:32] ||
            (bus_ctl_o & LOOPS) !== ctl_of(p[52:48])) e4++;
      end else if (busy_e) begin
        if (bus_ctl_o[2] || bus_ctl_o[1] !== stb_e || bus_data_oe || bus_addr_oe ||
            (bus_ctl_oe & LOOPS) != 0 || clash) e5++;
      end else begin
        if (bus_ctl_o[2] || bus_ctl_o[1] || bus_data_oe || bus_addr_oe) e5++;
      end
      if (done !== done_e) e7++;
      if (mismatch !== (done_e && (f != 0))) e8++;
      if (n == 1)
        chk(!done && !mismatch, "R10", {tag, " flags cleared by start"},
            {62'd0, done, mismatch}, 64'd0);
      if (n == R_END + 1) begin
        chk(result === (p ^ f), "R6", {tag, " captured word"}, 64'(result), 64'(p ^ f));
        chk(mismatch === (f != 0), "R8", {tag, " mismatch flag"}, 64'(mismatch), 64'(f != 0));
      end
      if (n == inj_n) begin
        cmd_valid = 1'b1; cmd_op = inj_op; cmd_wdata = inj_d;
      end
    end
    chk(e3 == 0, "R3", {tag, " busy/test-mode bad cycles"}, 64'(e3), 64'd0);
    chk(e4 == 0, "R4", {tag, " write-phase bad cycles"}, 64'(e4), 64'd0);
    chk(e5 == 0, "R5", {tag, " read-phase bad cycles"}, 64'(e5), 64'd0);
    chk(e7 == 0, "R7", {tag, " done timing bad cycles"}, 64'(e7), 64'd0);
    chk(e8 == 0, "R8", {tag, " mismatch timing bad cycles"}, 64'(e8), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PW-1:0] keep;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mismatch, "R1", "reset flags", {61'd0, busy, done, mismatch}, 64'd0);
    chk(result === '0, "R1", "reset result", 64'(result), 64'd0);
    chk(!bus_data_oe && !bus_addr_oe && (bus_ctl_oe & LOOPS) == 0 && bus_ctl_o == 0,
        "R1", "reset bus", {48'd0, bus_ctl_oe, bus_ctl_o}, {48'd0, bus_ctl_oe & ~LOOPS, 8'h00});
    rst_n = 1'b1;

    // R2 R4 R6 R8 vector table
    for (int i = 0; i < 7; i++)
      run_test(VEC[i][2*PW-1:PW], VEC[i][PW-1:0], 1'b1, 0, 2'd3, 32'd0, $sformatf("vec%0d", i));

    // R9 start in the middle of a run is ignored
    run_test(P_555, '0, 1'b1, 6, 2'd2, 32'd0, "start-mid");

    // R9 load in the middle of a run is ignored; rerun without load
    run_test(P_AAA, '0, 1'b1, 3, 2'd0, 32'h1234_5678, "load-mid");
    run_test(P_AAA, '0, 1'b0, 0, 2'd3, 32'd0, "rerun-no-load");

    // completion and a start in the same cycle: start is ignored (R9, R7)
    run_test(P_ONES, 53'd1 << 20, 1'b1, R_END, 2'd2, 32'd0, "start-at-finish");
    repeat (3) @(negedge clk);
    chk(!busy && done && mismatch, "R9", "start in final busy cycle ignored",
        {61'd0, busy, done, mismatch}, 64'd3);

    // R10 clean run after a failing run clears mismatch
    run_test(P_ZERO, '0, 1'b1, 0, 2'd3, 32'd0, "clean-after-fail");

    // R2 code 3 has no effect
    keep = result;
    send(2'd3, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    chk(!busy && done && !mismatch && result === keep, "R2", "code 3 no effect",
        64'(result), 64'(keep));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule